// File: doc/BRIEF.md
# Gain-blended threshold lookup

This block supplies, for every incoming pixel, the integer threshold that a later stage uses to decide whether a neighbouring pixel is close enough to the window centre to join the smoothing. It holds one threshold table per calibrated camera gain. Each table has one entry for every possible intensity. The pixel intensity that is about to become the window centre addresses all tables at once. A pair-select input names the two adjacent gain tables that bracket the current camera gain. The two entries read from those tables are blended linearly with two weights. The weights are computed off-block, and the blended value is rounded to the nearest integer and clipped.

The tables are filled through a simple write port, normally once at start-up. The pair select and the two weights are sampled together with each pixel, so they can change between frames without disturbing pixels already in flight. The result follows its pixel by a fixed three clocks. This lets the caller issue a lookup early enough that the threshold arrives just as the window is evaluated.

Top module: `gain_thr_interp`

## Requirements
- R1: There are four tables of 256 entries of 8 bits each. When `tbl_wr_en` is high at a rising clock edge, entry `tbl_wr_addr` of table `tbl_wr_sel` takes `tbl_wr_data`, and no other table or entry changes.
- R2: All four tables are read in the same cycle at address `pix_in`. A lookup issued in the same cycle as a write to the same entry returns the entry's content from before that write.
- R3: `pair_sel` value s (0, 1 or 2) makes table s the lower entry and table s+1 the upper entry. The value 3 selects the same pair as 2 (tables 2 and 3).
- R4: The weights `w_lower` and `w_upper` are unsigned 9-bit fractions with 8 fractional bits, so 256 means 1.0. The blend is lower entry times `w_lower` plus upper entry times `w_upper`. With equal entries and weights summing to 256, the result equals that entry.
- R5: The blend sum is rounded by adding its bit 7 to the sum shifted right by 8. Exactly one half rounds up.
- R6: A rounded value above 255 gives 255 on `thr_out`.
- R7: `thr_valid` is high exactly three clock edges after an edge at which `pix_valid` was high, and low otherwise. The pair select and the weights are taken from the same cycle as the pixel.
- R8: While `rst_n` is low and after it is released, `thr_valid` and `thr_out` are 0 until the first result.
- R9: `thr_out` keeps its last value while `thr_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset of the pipeline control and output |
| tbl_wr_en | input | 1 | Table write strobe |
| tbl_wr_sel | input | 2 | Table index for the write |
| tbl_wr_addr | input | 8 | Entry index for the write |
| tbl_wr_data | input | 8 | Threshold value written |
| pix_valid | input | 1 | A lookup is issued this cycle |
| pix_in | input | 8 | Intensity of the future window centre, used as the table address |
| pair_sel | input | 2 | Lower table index of the bracketing pair |
| w_lower | input | 9 | Weight of the lower entry, 8 fractional bits |
| w_upper | input | 9 | Weight of the upper entry, 8 fractional bits |
| thr_valid | output | 1 | Threshold on `thr_out` is new this cycle |
| thr_out | output | 8 | Rounded, clipped threshold |

## Verification
Every pair select is driven with streams of consecutive pixels under four weight settings. The settings are the lower weight alone, the upper weight alone, an even split and an uneven split. The first two show whether the right table feeds each side of the blend, and the last two show whether the arithmetic combines them correctly. Entries whose blends land just below, exactly on, and just above one half separate correct rounding from truncation. A pair of full-scale entries with oversized weights exposes a missing clip. A write and a lookup to the same entry in one cycle, followed by a lookup of the neighbouring table, separate read-before-write ordering from write-through and from writes that leak into other tables.

// File: rtl/thr_interp_pkg.sv
package thr_interp_pkg;

  localparam int unsigned DEF_PIX_W    = 8;
  localparam int unsigned DEF_THR_W    = 8;
  localparam int unsigned DEF_NUM_GAIN = 4;
  localparam int unsigned DEF_FRAC_W   = 8;

  // Lower table of the bracketing pair; selects past the last pair reuse it.
  function automatic int unsigned lower_gain(int unsigned sel, int unsigned ngain);
    return (sel > ngain - 2) ? ngain - 2 : sel;
  endfunction

endpackage

// File: rtl/thr_table_bank.sv
module thr_table_bank #(
  parameter int unsigned PIX_W    = 8,
  parameter int unsigned THR_W    = 8,
  parameter int unsigned NUM_GAIN = 4,
  localparam int unsigned DEPTH   = 1 << PIX_W,
  localparam int unsigned GIDX_W  = $clog2(NUM_GAIN)
) (
  input  logic                             clk,
  input  logic                             wr_en,
  input  logic [GIDX_W-1:0]                wr_sel,
  input  logic [PIX_W-1:0]                 wr_addr,
  input  logic [THR_W-1:0]                 wr_data,
  input  logic                             rd_en,
  input  logic [PIX_W-1:0]                 rd_addr,
  output logic [NUM_GAIN-1:0][THR_W-1:0]   rd_data,
  output logic [NUM_GAIN-1:0]              wr_hit
);

  for (genvar g = 0; g < NUM_GAIN; g++) begin : g_tbl
    logic [THR_W-1:0] mem_q [DEPTH];
    logic [THR_W-1:0] rd_q;

    assign wr_hit[g] = wr_en && (wr_sel == GIDX_W'(g));

    // Read returns the stored word before any same-edge write lands.
    always_ff @(posedge clk) begin
      if (wr_hit[g]) mem_q[wr_addr] <= wr_data;
      if (rd_en)     rd_q <= mem_q[rd_addr];
    end

    assign rd_data[g] = rd_q;
  end

endmodule

// File: rtl/thr_pair_select.sv
module thr_pair_select #(
  parameter int unsigned THR_W    = 8,
  parameter int unsigned NUM_GAIN = 4,
  localparam int unsigned GIDX_W  = $clog2(NUM_GAIN)
) (
  input  logic [NUM_GAIN-1:0][THR_W-1:0] rd_data,
  input  logic [GIDX_W-1:0]              sel,
  output logic [THR_W-1:0]               lo_ent,
  output logic [THR_W-1:0]               hi_ent
);
  import thr_interp_pkg::*;

  logic [GIDX_W-1:0] lo_idx;
  logic [GIDX_W-1:0] hi_idx;

  always_comb begin
    lo_idx = GIDX_W'(lower_gain(32'(sel), NUM_GAIN));
    hi_idx = lo_idx + GIDX_W'(1);
    lo_ent = rd_data[lo_idx];
    hi_ent = rd_data[hi_idx];
  end

endmodule

// File: rtl/thr_blend.sv
module thr_blend #(
  parameter int unsigned THR_W  = 8,
  parameter int unsigned FRAC_W = 8,
  localparam int unsigned WGT_W  = FRAC_W + 1,
  localparam int unsigned PROD_W = THR_W + WGT_W,
  localparam int unsigned SUM_W  = PROD_W + 1,
  localparam int unsigned INT_W  = SUM_W - FRAC_W,
  localparam int unsigned RND_W  = INT_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [THR_W-1:0] lo_ent,
  input  logic [THR_W-1:0] hi_ent,
  input  logic [WGT_W-1:0] w_lo,
  input  logic [WGT_W-1:0] w_hi,
  output logic             mid_valid,
  output logic             sat_hit,
  output logic             out_valid,
  output logic [THR_W-1:0] out_thr
);

  localparam logic [RND_W-1:0] CLIP = RND_W'({THR_W{1'b1}});

  function automatic logic [PROD_W-1:0] f_weigh(logic [THR_W-1:0] ent, logic [WGT_W-1:0] w);
    return PROD_W'(ent) * PROD_W'(w);
  endfunction

  // Integer part plus the top fractional bit.
  function automatic logic [RND_W-1:0] f_round(logic [SUM_W-1:0] s);
    return RND_W'(s[SUM_W-1:FRAC_W]) + RND_W'(s[FRAC_W-1]);
  endfunction

  function automatic logic [THR_W-1:0] f_clip(logic [RND_W-1:0] r);
    return (r > CLIP) ? {THR_W{1'b1}} : r[THR_W-1:0];
  endfunction

  logic [PROD_W-1:0] p_lo_q, p_hi_q;
  logic [SUM_W-1:0]  sum_raw;
  logic [RND_W-1:0]  rounded;

  // Stage 2: the two products.
  always_ff @(posedge clk) begin
    if (!rst_n) mid_valid <= 1'b0;
    else        mid_valid <= in_valid;
    if (in_valid) begin
      p_lo_q <= f_weigh(lo_ent, w_lo);
      p_hi_q <= f_weigh(hi_ent, w_hi);
    end
  end

  always_comb begin
    sum_raw = SUM_W'(p_lo_q) + SUM_W'(p_hi_q);
    rounded = f_round(sum_raw);
    sat_hit = rounded > CLIP;
  end

  // Stage 3: sum, round, clip.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_thr   <= '0;
    end else begin
      out_valid <= mid_valid;
      if (mid_valid) out_thr <= f_clip(rounded);
    end
  end

endmodule

// File: rtl/gain_thr_interp.sv
module gain_thr_interp #(
  parameter int unsigned PIX_W    = thr_interp_pkg::DEF_PIX_W,
  parameter int unsigned THR_W    = thr_interp_pkg::DEF_THR_W,
  parameter int unsigned NUM_GAIN = thr_interp_pkg::DEF_NUM_GAIN,
  parameter int unsigned FRAC_W   = thr_interp_pkg::DEF_FRAC_W,
  localparam int unsigned GIDX_W  = $clog2(NUM_GAIN),
  localparam int unsigned WGT_W   = FRAC_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tbl_wr_en,
  input  logic [GIDX_W-1:0] tbl_wr_sel,
  input  logic [PIX_W-1:0]  tbl_wr_addr,
  input  logic [THR_W-1:0]  tbl_wr_data,
  input  logic              pix_valid,
  input  logic [PIX_W-1:0]  pix_in,
  input  logic [GIDX_W-1:0] pair_sel,
  input  logic [WGT_W-1:0]  w_lower,
  input  logic [WGT_W-1:0]  w_upper,
  output logic              thr_valid,
  output logic [THR_W-1:0]  thr_out
);

  logic [NUM_GAIN-1:0][THR_W-1:0] rd_data;
  logic [NUM_GAIN-1:0]            wr_hit;
  logic                           s1_valid;
  logic [GIDX_W-1:0]              s1_sel;
  logic [WGT_W-1:0]               s1_wlo, s1_whi;
  logic [THR_W-1:0]               lo_ent, hi_ent;
  logic                           s2_valid;
  logic                           sat_hit;

  thr_table_bank #(.PIX_W(PIX_W), .THR_W(THR_W), .NUM_GAIN(NUM_GAIN)) u_bank (
    .clk     (clk),
    .wr_en   (tbl_wr_en),
    .wr_sel  (tbl_wr_sel),
    .wr_addr (tbl_wr_addr),
    .wr_data (tbl_wr_data),
    .rd_en   (pix_valid),
    .rd_addr (pix_in),
    .rd_data (rd_data),
    .wr_hit  (wr_hit)
  );

  // Stage 1: side data travels with the table read.
  always_ff @(posedge clk) begin
    if (!rst_n) s1_valid <= 1'b0;
    else        s1_valid <= pix_valid;
    if (pix_valid) begin
      s1_sel <= pair_sel;
      s1_wlo <= w_lower;
      s1_whi <= w_upper;
    end
  end

  thr_pair_select #(.THR_W(THR_W), .NUM_GAIN(NUM_GAIN)) u_pair (
    .rd_data (rd_data),
    .sel     (s1_sel),
    .lo_ent  (lo_ent),
    .hi_ent  (hi_ent)
  );

  thr_blend #(.THR_W(THR_W), .FRAC_W(FRAC_W)) u_blend (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (s1_valid),
    .lo_ent    (lo_ent),
    .hi_ent    (hi_ent),
    .w_lo      (s1_wlo),
    .w_hi      (s1_whi),
    .mid_valid (s2_valid),
    .sat_hit   (sat_hit),
    .out_valid (thr_valid),
    .out_thr   (thr_out)
  );

endmodule

// File: rtl/gain_thr_interp_chk.sv
module gain_thr_interp_chk #(
  parameter int unsigned THR_W    = 8,
  parameter int unsigned FRAC_W   = 8,
  parameter int unsigned NUM_GAIN = 4,
  localparam int unsigned WGT_W   = FRAC_W + 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                pix_valid,
  input logic [NUM_GAIN-1:0] wr_hit,
  input logic                s1_valid,
  input logic [WGT_W-1:0]    s1_wlo,
  input logic [WGT_W-1:0]    s1_whi,
  input logic [THR_W-1:0]    lo_ent,
  input logic [THR_W-1:0]    hi_ent,
  input logic                s2_valid,
  input logic                sat_hit,
  input logic                thr_valid,
  input logic [THR_W-1:0]    thr_out
);

  localparam logic [WGT_W:0] ONE = (WGT_W + 1)'(1 << FRAC_W);

  logic [WGT_W:0] wsum;
  assign wsum = {1'b0, s1_wlo} + {1'b0, s1_whi};

  // R1: a write touches at most one table
  a_r1_one_table: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_hit));

  // R4: equal entries with unit weight sum reproduce the entry
  a_r4_equal_entries: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && lo_ent == hi_ent && wsum == ONE) |-> ##2 (thr_out == $past(lo_ent, 2)));

  // R4: full lower weight gives the lower entry
  a_r4_lower_only: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1_wlo == WGT_W'(ONE) && s1_whi == '0) |-> ##2 (thr_out == $past(lo_ent, 2)));

  // R6: an oversize blend shows full scale
  a_r6_clip: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_valid && sat_hit) |=> (thr_out == {THR_W{1'b1}}));

  // R7: fixed three-edge latency
  a_r7_latency: assert property (@(posedge clk) disable iff (!rst_n)
    thr_valid == $past(pix_valid, 3));

  // R7: pipeline stages advance in step
  a_r7_stage_chain: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |=> s2_valid);

  // R9: output holds when no result
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !thr_valid |-> $stable(thr_out));

endmodule

bind gain_thr_interp gain_thr_interp_chk #(
  .THR_W(THR_W), .FRAC_W(FRAC_W), .NUM_GAIN(NUM_GAIN)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pix_valid (pix_valid),
  .wr_hit    (wr_hit),
  .s1_valid  (s1_valid),
  .s1_wlo    (s1_wlo),
  .s1_whi    (s1_whi),
  .lo_ent    (lo_ent),
  .hi_ent    (hi_ent),
  .s2_valid  (s2_valid),
  .sat_hit   (sat_hit),
  .thr_valid (thr_valid),
  .thr_out   (thr_out)
);

// File: tb/sim_gain_thr_interp.sv
module sim_gain_thr_interp;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tbl_wr_en = 1'b0;
  logic [1:0] tbl_wr_sel = '0;
  logic [7:0] tbl_wr_addr = '0;
  logic [7:0] tbl_wr_data = '0;
  logic       pix_valid = 1'b0;
  logic [7:0] pix_in = '0;
  logic [1:0] pair_sel = '0;
  logic [8:0] w_lower = '0;
  logic [8:0] w_upper = '0;
  logic       thr_valid;
  logic [7:0] thr_out;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  int mdl [4][256];
  int expq [64];

  always #4 clk = ~clk;

  gain_thr_interp u0 (
    .clk(clk), .rst_n(rst_n),
    .tbl_wr_en(tbl_wr_en), .tbl_wr_sel(tbl_wr_sel),
    .tbl_wr_addr(tbl_wr_addr), .tbl_wr_data(tbl_wr_data),
    .pix_valid(pix_valid), .pix_in(pix_in), .pair_sel(pair_sel),
    .w_lower(w_lower), .w_upper(w_upper),
    .thr_valid(thr_valid), .thr_out(thr_out)
  );

  function automatic int ref_thr(int sel, int pix, int wl, int wh);
    int lo_t = (sel > 2) ? 2 : sel;
    int s = mdl[lo_t][pix] * wl + mdl[lo_t + 1][pix] * wh;
    int r = (s + 128) / 256;
    return (r > 255) ? 255 : r;
  endfunction

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_entry(int t, int a, int d);
    @(negedge clk);
    tbl_wr_en = 1'b1; tbl_wr_sel = 2'(t); tbl_wr_addr = 8'(a); tbl_wr_data = 8'(d);
    mdl[t][a] = d;
    @(negedge clk);
    tbl_wr_en = 1'b0;
  endtask

  // One lookup; output sampled three edges later.
  task automatic one_lookup(string req, int sel, int pix, int wl, int wh, int exp);
    @(negedge clk);
    pix_valid = 1'b1; pix_in = 8'(pix); pair_sel = 2'(sel);
    w_lower = 9'(wl); w_upper = 9'(wh);
    @(negedge clk); pix_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check({req, " valid"}, int'(thr_valid), 1);
    check(req, int'(thr_out), exp);
  endtask

  task automatic t_reset();
    check("R8 valid in reset", int'(thr_valid), 0);
    check("R8 out in reset", int'(thr_out), 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R8 valid after reset", int'(thr_valid), 0);
    check("R8 out after reset", int'(thr_out), 0);
  endtask

  task automatic t_load();
    for (int t = 0; t < 4; t++)
      for (int a = 0; a < 256; a++) begin
        @(negedge clk);
        tbl_wr_en = 1'b1; tbl_wr_sel = 2'(t); tbl_wr_addr = 8'(a);
        tbl_wr_data = 8'((a * (2 * t + 3) + 37 * t) % 256);
        mdl[t][a] = (a * (2 * t + 3) + 37 * t) % 256;
      end
    @(negedge clk); tbl_wr_en = 1'b0;
  endtask

  // Back-to-back stream, R3/R4/R7 checked per item.
  task automatic t_stream(int sel, int wl, int wh, int pix0);
    for (int c = 0; c < 11; c++) begin
      @(negedge clk);
      if (c >= 3) begin
        check("R7 stream valid", int'(thr_valid), 1);
        check("R3 R4 stream value", int'(thr_out), expq[c - 3]);
      end else begin
        check("R7 idle before result", int'(thr_valid), 0);
      end
      if (c < 8) begin
        pix_valid = 1'b1; pix_in = 8'(pix0 + 29 * c); pair_sel = 2'(sel);
        w_lower = 9'(wl); w_upper = 9'(wh);
        expq[c] = ref_thr(sel, (pix0 + 29 * c) % 256, wl, wh);
      end else begin
        pix_valid = 1'b0;
      end
    end
    @(negedge clk);
    check("R7 valid drops", int'(thr_valid), 0);
  endtask

  task automatic t_round();
    wr_entry(0, 250, 10);
    wr_entry(1, 250, 11);
    one_lookup("R5 exact half", 0, 250, 128, 128, 11);
    one_lookup("R5 above half", 0, 250, 64, 192, 11);
    one_lookup("R5 below half", 0, 250, 200, 56, 10);
    one_lookup("R5 just under half", 0, 250, 129, 127, 10);
  endtask

  task automatic t_saturate();
    wr_entry(2, 200, 255);
    wr_entry(3, 200, 255);
    one_lookup("R6 clip", 2, 200, 200, 200, 255);
    one_lookup("R6 clip max weights", 3, 200, 511, 511, 255);
    one_lookup("R4 full scale unit", 2, 200, 100, 156, 255);
  endtask

  task automatic t_rdw();
    int old_v = mdl[0][5];
    @(negedge clk);
    tbl_wr_en = 1'b1; tbl_wr_sel = 2'd0; tbl_wr_addr = 8'd5; tbl_wr_data = 8'(old_v ^ 8'h5a);
    pix_valid = 1'b1; pix_in = 8'd5; pair_sel = 2'd0; w_lower = 9'd256; w_upper = 9'd0;
    @(negedge clk);
    tbl_wr_en = 1'b0; pix_valid = 1'b0;
    mdl[0][5] = old_v ^ 8'h5a;
    @(negedge clk);
    @(negedge clk);
    check("R2 read before write", int'(thr_out), old_v);
    one_lookup("R1 new content", 0, 5, 256, 0, mdl[0][5]);
    one_lookup("R1 other table intact", 0, 5, 0, 256, mdl[1][5]);
  endtask

  task automatic t_hold();
    int held;
    one_lookup("R4 uneven", 1, 77, 90, 166, ref_thr(1, 77, 90, 166));
    held = int'(thr_out);
    @(negedge clk);
    pix_in = 8'd3; pair_sel = 2'd3; w_lower = 9'd7; w_upper = 9'd9;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R9 hold value", int'(thr_out), held);
      check("R9 no valid", int'(thr_valid), 0);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_load();
    for (int s = 0; s < 4; s++) begin
      t_stream(s, 256, 0, 11 + s);
      t_stream(s, 0, 256, 40 + s);
      t_stream(s, 128, 128, 90 + s);
      t_stream(s, 90, 166, 150 + s);
    end
    one_lookup("R3 select 3 same as 2", 3, 60, 0, 256, mdl[3][60]);
    one_lookup("R3 select 3 lower side", 3, 60, 256, 0, mdl[2][60]);
    t_round();
    t_saturate();
    t_rdw();
    t_hold();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule